// File: doc/BRIEF.md
# Display Power Sequencing Controller

This block sequences a display panel interface through four stages: pixel clock, sync generation, the display-enable signal and the backlight PWM. Software raises a stage by writing a one to that stage's bit on a set port and lowers it by writing a one to its bit on a separate clear port. Each stage has an enable output and a status output. The status follows the enable only once the stage's own transition has finished, and that transition is timed by pixel-clock ticks and frame-end ticks from the timing core.

Stages are brought up in the order clock, sync, display, PWM. A set is accepted only when the previous stage's status reads 1. A clear is refused while a stage that comes later in that order, among clock, sync and display, is still enabled or still reports active. The PWM stage may be cleared at any time. The display stage waits a programmable number of frames, the guard time, after it is enabled before it reports active.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While reset is low, at the next clock edge every enable bit and every status bit is 0.
- R2: Bit positions are 0 clock, 1 sync, 2 display, 3 PWM. A set write with bit i high sets enable i when i is 0 or when status i-1 is 1. Bits already set stay set, and zero bits in the write change nothing.
- R3: A set of stage i (i greater than 0) whose status i-1 is 0 is ignored, and enable i stays 0.
- R4: A clear write with bit i high clears enable i when no later stage among clock, sync and display has its enable or its status at 1. The PWM bit is always cleared.
- R5: A clear of a stage is ignored while a later stage among clock, sync and display is enabled or active.
- R6: The clock status takes the clock enable value on the CLK_SETTLE-th (default 2) pix_tick sampled while the two differ. If they become equal before that, the count restarts.
- R7: The sync status takes the sync enable value at the first frame_tick sampled while the two differ.
- R8: The display status rises at the G-th frame_tick sampled while the display is enabled and inactive, where G is guard_frames, or 1 when guard_frames is 0. It falls at the first frame_tick sampled after the enable is cleared.
- R9: The PWM status equals the PWM enable of the previous cycle.
- R10: When an accepted clear and a set hit the same bit in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_wr | input | 1 | Set-register write strobe |
| set_bits | input | 4 | Write-one-to-set stage bits |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_bits | input | 4 | Write-one-to-clear stage bits |
| guard_frames | input | GUARD_W | Frames from display enable to display active |
| pix_tick | input | 1 | One pulse per pixel-clock cycle |
| frame_tick | input | 1 | One pulse per frame end |
| stage_en | output | 4 | Per-stage enables |
| stage_sts | output | 4 | Per-stage status |

## Verification
A full power-up followed by a power-down in the intended order checks that every enable is accepted and that each status lags by its own kind of delay: pixel ticks, frame ticks, guard frames or a single cycle. Writes out of order, such as sync before clock, or clock and sync cleared while the display is still active or still falling, separate the set and clear gating from plain bit storage. A clock transition broken off part way shows that the settle count restarts. A guard time of 0 set against a guard time of 3 shows how the minimum guard is handled. Combined set and clear writes show which one has priority.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    localparam int NSTG = 4;
    typedef enum int {
        STG_CLK  = 0,
        STG_SYNC = 1,
        STG_DISP = 2,
        STG_PWM  = 3
    } stage_e;
endpackage

// File: rtl/pwrseq_cmd.sv
module pwrseq_cmd
    import pwrseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_wr,
    input  logic [NSTG-1:0] set_bits,
    input  logic            clr_wr,
    input  logic [NSTG-1:0] clr_bits,
    input  logic [NSTG-1:0] sts,
    output logic [NSTG-1:0] en
);
    typedef struct packed {
        logic [NSTG-1:0] en;
    } cmd_t;

    cmd_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < NSTG; i++) begin
            logic later_on;
            logic set_ok;
            logic clr_ok;
            later_on = 1'b0;
            // PWM is not a blocker: only clock, sync and display gate clears
            for (int j = i + 1; j < int'(STG_PWM); j++) begin
                later_on = later_on | q.en[j] | sts[j];
            end
            set_ok = set_wr && set_bits[i] && ((i == 0) || sts[(i == 0) ? 0 : i - 1]);
            clr_ok = clr_wr && clr_bits[i] && !later_on;
            if (clr_ok)
                d.en[i] = 1'b0;
            else if (set_ok)
                d.en[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en = q.en;
endmodule

// File: rtl/pwrseq_stage.sv
module pwrseq_stage #(
    parameter int KIND       = 0,
    parameter int GUARD_W    = 4,
    parameter int CLK_SETTLE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               pix_tick,
    input  logic               frame_tick,
    input  logic [GUARD_W-1:0] guard_frames,
    output logic               sts
);
    localparam int SET_W = $clog2(CLK_SETTLE + 1);
    localparam int CNT_W = (GUARD_W > SET_W) ? GUARD_W : SET_W;

    typedef struct packed {
        logic             sts;
        logic [CNT_W-1:0] cnt;
    } stg_t;

    stg_t q, d;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] guard_tgt;

    assign cnt_inc   = q.cnt + CNT_W'(1);
    assign guard_tgt = (guard_frames == '0) ? CNT_W'(1) : CNT_W'(guard_frames);

    always_comb begin
        d = q;
        case (KIND)
            0: begin
                if (en != q.sts) begin
                    if (pix_tick) begin
                        if (cnt_inc >= CNT_W'(CLK_SETTLE)) begin
                            d.sts = en;
                            d.cnt = '0;
                        end else begin
                            d.cnt = cnt_inc;
                        end
                    end
                end else begin
                    d.cnt = '0;
                end
            end
            1: begin
                d.cnt = '0;
                if (en != q.sts && frame_tick) d.sts = en;
            end
            2: begin
                if (en && !q.sts) begin
                    if (frame_tick) begin
                        if (cnt_inc >= guard_tgt) begin
                            d.sts = 1'b1;
                            d.cnt = '0;
                        end else begin
                            d.cnt = cnt_inc;
                        end
                    end
                end else begin
                    d.cnt = '0;
                    if (!en && q.sts && frame_tick) d.sts = 1'b0;
                end
            end
            default: begin
                d.sts = en;
                d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sts = q.sts;
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int GUARD_W    = 4,
    parameter int CLK_SETTLE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_wr,
    input  logic [3:0]         set_bits,
    input  logic               clr_wr,
    input  logic [3:0]         clr_bits,
    input  logic [GUARD_W-1:0] guard_frames,
    input  logic               pix_tick,
    input  logic               frame_tick,
    output logic [3:0]         stage_en,
    output logic [3:0]         stage_sts
);
    logic [NSTG-1:0] en_w;
    logic [NSTG-1:0] sts_w;

    pwrseq_cmd i_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wr   (set_wr),
        .set_bits (set_bits),
        .clr_wr   (clr_wr),
        .clr_bits (clr_bits),
        .sts      (sts_w),
        .en       (en_w)
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        pwrseq_stage #(
            .KIND       (g),
            .GUARD_W    (GUARD_W),
            .CLK_SETTLE (CLK_SETTLE)
        ) i_stage (
            .clk          (clk),
            .rst_n        (rst_n),
            .en           (en_w[g]),
            .pix_tick     (pix_tick),
            .frame_tick   (frame_tick),
            .guard_frames (guard_frames),
            .sts          (sts_w[g])
        );
    end

    assign stage_en  = en_w;
    assign stage_sts = sts_w;
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_wr,
    input logic [3:0] set_bits,
    input logic       clr_wr,
    input logic [3:0] clr_bits,
    input logic       pix_tick,
    input logic       frame_tick,
    input logic [3:0] stage_en,
    input logic [3:0] stage_sts
);
    logic in_rst_q;
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    // R1: state observed after a reset edge is all zero
    always @(negedge clk) begin
        if (in_rst_q === 1'b1)
            assert_reset_clear_R1: assert (stage_en == 4'h0 && stage_sts == 4'h0);
    end

    assert_order_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en[1] |-> stage_sts[0]);
    assert_order_disp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en[2] |-> stage_sts[1]);

    assert_set_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && set_bits[2] && !stage_sts[1] && !stage_en[2]) |=> !stage_en[2]);

    assert_pwm_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits[3]) |=> !stage_en[3]);

    assert_clr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits[0] && stage_en[0] && (stage_en[1] || stage_sts[1])) |=> stage_en[0]);

    assert_clk_sts_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_tick |=> $stable(stage_sts[0]));

    assert_sync_sts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(stage_sts[1]));

    assert_disp_sts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(stage_sts[2]));

    assert_pwm_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en[3] |=> stage_sts[3]);
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_wr     (set_wr),
    .set_bits   (set_bits),
    .clr_wr     (clr_wr),
    .clr_bits   (clr_bits),
    .pix_tick   (pix_tick),
    .frame_tick (frame_tick),
    .stage_en   (stage_en),
    .stage_sts  (stage_sts)
);

// File: tb/test_pwrseq_ctrl.sv
`timescale 1ns/1ps
module test_pwrseq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_wr = 1'b0;
    logic [3:0] set_bits = 4'h0;
    logic       clr_wr = 1'b0;
    logic [3:0] clr_bits = 4'h0;
    logic [3:0] guard_frames = 4'd1;
    logic       pix_tick = 1'b0;
    logic       frame_tick = 1'b0;
    logic [3:0] stage_en;
    logic [3:0] stage_sts;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwrseq_ctrl i_pwrseq_ctrl (
        .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .set_bits(set_bits),
        .clr_wr(clr_wr), .clr_bits(clr_bits), .guard_frames(guard_frames),
        .pix_tick(pix_tick), .frame_tick(frame_tick),
        .stage_en(stage_en), .stage_sts(stage_sts)
    );

    // behavioural reference model
    bit m_en[4];
    bit m_st[4];
    int m_ccnt = 0;
    int m_dcnt = 0;

    always @(posedge clk) begin
        bit n_en[4];
        bit n_st[4];
        int g;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_st[i] = 0; end
            m_ccnt = 0; m_dcnt = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                bit busy;
                bit s_ok;
                bit c_ok;
                busy = 0;
                for (int j = i + 1; j < 3; j++) if (m_en[j] || m_st[j]) busy = 1;
                s_ok = set_wr && set_bits[i] && (i == 0 || m_st[(i == 0) ? 0 : i - 1]);
                c_ok = clr_wr && clr_bits[i] && !busy;
                n_en[i] = c_ok ? 0 : (s_ok ? 1 : m_en[i]);
                n_st[i] = m_st[i];
            end
            if (m_en[0] != m_st[0]) begin
                if (pix_tick) begin
                    m_ccnt++;
                    if (m_ccnt >= 2) begin n_st[0] = m_en[0]; m_ccnt = 0; end
                end
            end else m_ccnt = 0;
            if (m_en[1] != m_st[1] && frame_tick) n_st[1] = m_en[1];
            g = (guard_frames == 0) ? 1 : int'(guard_frames);
            if (m_en[2] && !m_st[2]) begin
                if (frame_tick) begin
                    m_dcnt++;
                    if (m_dcnt >= g) begin n_st[2] = 1; m_dcnt = 0; end
                end
            end else begin
                m_dcnt = 0;
                if (!m_en[2] && m_st[2] && frame_tick) n_st[2] = 0;
            end
            n_st[3] = m_en[3];
            for (int i = 0; i < 4; i++) begin m_en[i] = n_en[i]; m_st[i] = n_st[i]; end
        end
    end

    function automatic logic [3:0] pack4(bit v[4]);
        return {v[3], v[2], v[1], v[0]};
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (stage_en !== pack4(m_en) || stage_sts !== pack4(m_st)) begin
                n_fail++;
                $display("FAIL R2 R6 model compare: en=%b sts=%b expected en=%b sts=%b",
                         stage_en, stage_sts, pack4(m_en), pack4(m_st));
            end
        end
    end

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cyc(bit sw, logic [3:0] sb, bit cw, logic [3:0] cb, bit pt, bit ft);
        @(negedge clk);
        set_wr = sw; set_bits = sb; clr_wr = cw; clr_bits = cb;
        pix_tick = pt; frame_tick = ft;
        @(posedge clk);
        #2;
        @(negedge clk);
        set_wr = 0; set_bits = 0; clr_wr = 0; clr_bits = 0; pix_tick = 0; frame_tick = 0;
    endtask

    task automatic setb(logic [3:0] b); cyc(1, b, 0, 0, 0, 0); endtask
    task automatic clrb(logic [3:0] b); cyc(0, 0, 1, b, 0, 0); endtask
    task automatic ptk(); cyc(0, 0, 0, 0, 1, 0); endtask
    task automatic ftk(); cyc(0, 0, 0, 0, 0, 1); endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset en", stage_en, 4'h0);
        chk("R1 reset sts", stage_sts, 4'h0);
        @(negedge clk); rst_n = 1;

        setb(4'b0010);                       chk("R3 sync before clock", stage_en, 4'b0000);
        setb(4'b0001);                       chk("R2 clock set", stage_en, 4'b0001);
        ptk();                               chk("R6 one tick", stage_sts, 4'b0000);
        ptk();                               chk("R6 two ticks", stage_sts, 4'b0001);
        setb(4'b0010);                       chk("R2 set keeps bits", stage_en, 4'b0011);
        chk("R7 sync waits frame", stage_sts, 4'b0001);
        ftk();                               chk("R7 sync at frame", stage_sts, 4'b0011);
        guard_frames = 4'd3;
        setb(4'b0100);                       chk("R2 display set", stage_en, 4'b0111);
        ftk(); ftk();                        chk("R8 guard not done", stage_sts, 4'b0011);
        ftk();                               chk("R8 guard third frame", stage_sts, 4'b0111);
        setb(4'b1000);                       chk("R9 pwm set", stage_en, 4'b1111);
        cyc(0, 0, 0, 0, 0, 0);               chk("R9 pwm status", stage_sts, 4'b1111);
        clrb(4'b0010);                       chk("R5 sync clear refused", stage_en, 4'b1111);
        clrb(4'b0001);                       chk("R5 clock clear refused", stage_en, 4'b1111);
        clrb(4'b0100);                       chk("R4 display clear", stage_en, 4'b1011);
        clrb(4'b0010);                       chk("R5 clear refused while display falls", stage_en, 4'b1011);
        ftk();                               chk("R8 display falls", stage_sts, 4'b1011);
        clrb(4'b0010);                       chk("R4 sync clear", stage_en, 4'b1001);
        ftk();                               chk("R7 sync falls", stage_sts, 4'b1001);
        cyc(1, 4'b0001, 1, 4'b0001, 0, 0);   chk("R10 clear wins", stage_en, 4'b1000);
        ptk(); ptk();                        chk("R6 clock falls", stage_sts, 4'b1000);
        clrb(4'b1000);                       chk("R4 pwm clear", stage_en, 4'b0000);
        cyc(0, 0, 0, 0, 0, 0);               chk("R9 pwm falls", stage_sts, 4'b0000);

        setb(4'b0001); ptk(); clrb(4'b0001); ptk(); ptk();
        chk("R6 aborted transition", stage_sts, 4'b0000);
        setb(4'b0001); ptk();
        chk("R6 count restarted", stage_sts, 4'b0000);
        ptk(); setb(4'b0010); ftk();
        guard_frames = 4'd0;
        setb(4'b0100); ftk();                chk("R8 guard zero is one", stage_sts, 4'b0111);
        @(negedge clk); rst_n = 0;
        @(posedge clk); #2;
        chk("R1 reset in run en", stage_en, 4'h0);
        chk("R1 reset in run sts", stage_sts, 4'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule